// File: doc/BRIEF.md
# Transactional Side Cache Controller

This block is the tag and state controller of a small fully associative cache that sits beside a core's primary data cache and holds no line that the primary cache holds. Each entry keeps a line address tag and a two-bit transactional state. Local requests arrive with a write flag and a transaction-mode flag, and the controller reports a hit at once. On a miss it claims an entry for the incoming line. A transactional write keeps a saved pre-transaction copy next to a speculative working copy, so that an aborted transaction can fall back to the old data without going to shared memory.

Snoops from other cores are compared against the speculative copies. If a snoop touches one, the local transaction aborts. The controller handles commit and abort, whether commanded or raised inside the block, with a single-cycle sweep over all entries. A commit reports, as an entry bitmap, the lines whose speculative data has just become publishable and may be written back. The data array, the bus protocol and memory timing belong to neighbouring blocks.

Top module: `tsc_ctrl`

## Requirements
- R1: After reset every entry is empty: the first request misses, and no abort or write-back pulse is raised.
- R2: A request hits (req_hit_o high in the same cycle) exactly when its line address (address bits above the log2(LINE_BYTES) offset bits) matches an entry in state Normal (01) or Speculative (11). The offset bits are ignored and a Saved (10) entry never hits.
- R3: A miss by a non-transactional access or a transactional read claims one entry as Normal with the request's tag, so a later access to the same line hits.
- R4: Victim choice takes the lowest-index Empty (00) entry if one exists, otherwise the lowest-index Normal entry. A line whose entry is claimed no longer hits.
- R5: A transactional write that hits a Normal line turns that entry into Saved and claims one other entry as Speculative with the same tag. A transactional write that misses claims two entries, the first chosen as Saved and the second as Speculative. A transactional write that hits a Speculative line claims nothing.
- R6: A snoop whose line address matches a Speculative entry raises abort_o and abort_conflict_o in the cycle after the snoop. A snoop that matches only Normal or Saved entries raises nothing.
- R7: An abort sweep, whether from a conflict, an overflow or txn_abort_i, turns every Speculative entry Empty and every Saved entry Normal in one cycle. A commanded abort raises no abort_o.
- R8: txn_commit_i turns every Saved entry Empty and every Speculative entry Normal in one cycle. In the next cycle wb_valid_o is high and wb_mask_o bit i is set exactly for entries i that were Speculative.
- R9: A request that must claim more entries than there are Empty or Normal entries (after any entry it converts) is not performed. It raises abort_o and abort_overflow_o in the next cycle and triggers the abort sweep.
- R10: Priority per cycle is snoop conflict or txn_abort_i, then txn_commit_i, then the request. A request in a cycle with a commit or abort is ignored, and a commit coinciding with a conflict is dropped with no write-back pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Local request present |
| req_write_i | input | 1 | Request is a write |
| req_txn_i | input | 1 | Request is issued in transactional mode |
| req_addr_i | input | ADDR_W | Request byte address |
| req_hit_o | output | 1 | Request hits a visible entry (combinational) |
| snoop_valid_i | input | 1 | Access from another core present |
| snoop_addr_i | input | ADDR_W | Snoop byte address |
| txn_commit_i | input | 1 | Commit the current transaction |
| txn_abort_i | input | 1 | Abort the current transaction |
| abort_o | output | 1 | Abort raised inside the block (one-cycle pulse) |
| abort_conflict_o | output | 1 | Abort cause: snoop hit a speculative line |
| abort_overflow_o | output | 1 | Abort cause: no entry left to claim |
| wb_valid_o | output | 1 | Commit done, write-back bitmap valid (one-cycle pulse) |
| wb_mask_o | output | ENTRIES | Entries holding newly publishable lines |

## Verification
A wrong state in an entry stays hidden until a later access exposes it. A lost Saved copy shows up as a miss on the first read after an abort. A stray Speculative entry shows up as an extra bit in wb_mask_o on the next commit. A wrong victim shows up as a miss on a line that should still be resident. The bench therefore follows every transaction with reads, snoops and an empty-bitmap commit that expose the entry states within a few cycles. Victim order is checked by filling a four-entry configuration to exhaustion several times.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [1:0] {
      LS_FREE   = 2'b00,
      LS_PLAIN  = 2'b01,
      LS_SAVED  = 2'b10,
      LS_SPEC   = 2'b11
   } lstate_e;
endpackage

// File: rtl/tsc_match.sv
module tsc_match #(
   parameter int N  = 64,
   parameter int TW = 27
) (
   input  logic [TW-1:0] tags_i [N],
   input  logic [TW-1:0] key_i,
   output logic [N-1:0]  eq_o
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign eq_o[i] = (tags_i[i] == key_i);
   end
endmodule

// File: rtl/tsc_victim.sv
module tsc_victim #(
   parameter int N  = 64,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  free_i,
   input  logic [N-1:0]  plain_i,
   input  logic [N-1:0]  excl_i,
   output logic          a_ok_o,
   output logic [IW-1:0] a_idx_o,
   output logic          b_ok_o,
   output logic [IW-1:0] b_idx_o
);
   function automatic logic [IW-1:0] lowest(input logic [N-1:0] m);
      logic [IW-1:0] r;
      r = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (m[i]) r = IW'(i);
      end
      return r;
   endfunction

   logic [N-1:0] fa, pa, pool_a, fb, pb, pool_b, sel_a;

   always_comb begin
      fa      = free_i  & ~excl_i;
      pa      = plain_i & ~excl_i;
      pool_a  = (|fa) ? fa : pa;
      a_ok_o  = |pool_a;
      a_idx_o = lowest(pool_a);
      sel_a   = a_ok_o ? (N'(1) << a_idx_o) : '0;
      fb      = fa & ~sel_a;
      pb      = pa & ~sel_a;
      pool_b  = (|fb) ? fb : pb;
      b_ok_o  = |pool_b;
      b_idx_o = lowest(pool_b);
   end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
   import tsc_pkg::*;
#(
   parameter int ENTRIES    = 64,
   parameter int LINE_BYTES = 32,
   parameter int ADDR_W     = 32,
   localparam int OW = $clog2(LINE_BYTES),
   localparam int TW = ADDR_W - OW,
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic               req_txn_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   output logic               req_hit_o,
   input  logic               snoop_valid_i,
   input  logic [ADDR_W-1:0]  snoop_addr_i,
   input  logic               txn_commit_i,
   input  logic               txn_abort_i,
   output logic               abort_o,
   output logic               abort_conflict_o,
   output logic               abort_overflow_o,
   output logic               wb_valid_o,
   output logic [ENTRIES-1:0] wb_mask_o
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tsc_ctrl: ENTRIES must be at least 2");
   end
   if ((LINE_BYTES < 2) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("tsc_ctrl: LINE_BYTES must be a power of two");
   end
   if (TW < 1) begin : g_bad_addr
      $error("tsc_ctrl: ADDR_W too small for LINE_BYTES");
   end

   lstate_e      st_q [ENTRIES];
   lstate_e      st_d [ENTRIES];
   logic [TW-1:0] tag_q [ENTRIES];
   logic [TW-1:0] tag_d [ENTRIES];

   logic [ENTRIES-1:0] free_m, plain_m, saved_m, spec_m;
   logic [ENTRIES-1:0] req_eq, snp_eq, hit_plain, hit_spec, excl_m;
   logic [TW-1:0]      req_key, snp_key;

   assign req_key = req_addr_i[ADDR_W-1:OW];
   assign snp_key = snoop_addr_i[ADDR_W-1:OW];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_mask
      assign free_m[i]  = (st_q[i] == LS_FREE);
      assign plain_m[i] = (st_q[i] == LS_PLAIN);
      assign saved_m[i] = (st_q[i] == LS_SAVED);
      assign spec_m[i]  = (st_q[i] == LS_SPEC);
   end

   tsc_match #(.N(ENTRIES), .TW(TW)) u_req_cam (
      .tags_i (tag_q),
      .key_i  (req_key),
      .eq_o   (req_eq)
   );

   tsc_match #(.N(ENTRIES), .TW(TW)) u_snp_cam (
      .tags_i (tag_q),
      .key_i  (snp_key),
      .eq_o   (snp_eq)
   );

   assign hit_plain = req_eq & plain_m;
   assign hit_spec  = req_eq & spec_m;
   assign req_hit_o = req_valid_i & (|(hit_plain | hit_spec));

   logic spec_wr, convert, need1, need2, go_req, snp_conf, ovf, abort_go, commit_go;
   logic a_ok, b_ok;
   logic [IW-1:0] a_idx, b_idx;

   assign snp_conf  = snoop_valid_i & (|(snp_eq & spec_m));
   assign go_req    = req_valid_i & ~snp_conf & ~txn_abort_i & ~txn_commit_i;
   assign spec_wr   = req_write_i & req_txn_i;
   assign convert   = spec_wr & ~(|hit_spec) & (|hit_plain);
   assign need1     = spec_wr ? convert : ~(|(hit_plain | hit_spec));
   assign need2     = spec_wr & ~(|hit_spec) & ~(|hit_plain);
   assign excl_m    = convert ? hit_plain : '0;

   tsc_victim #(.N(ENTRIES)) u_victim (
      .free_i  (free_m),
      .plain_i (plain_m),
      .excl_i  (excl_m),
      .a_ok_o  (a_ok),
      .a_idx_o (a_idx),
      .b_ok_o  (b_ok),
      .b_idx_o (b_idx)
   );

   assign ovf       = go_req & ((need1 & ~a_ok) | (need2 & ~(a_ok & b_ok)));
   assign abort_go  = snp_conf | txn_abort_i | ovf;
   assign commit_go = txn_commit_i & ~snp_conf & ~txn_abort_i;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         st_d[i]  = st_q[i];
         tag_d[i] = tag_q[i];
         if (abort_go) begin
            if (st_q[i] == LS_SPEC)       st_d[i] = LS_FREE;
            else if (st_q[i] == LS_SAVED) st_d[i] = LS_PLAIN;
         end else if (commit_go) begin
            if (st_q[i] == LS_SAVED)      st_d[i] = LS_FREE;
            else if (st_q[i] == LS_SPEC)  st_d[i] = LS_PLAIN;
         end else if (go_req) begin
            if (convert && hit_plain[i]) st_d[i] = LS_SAVED;
            if (need1 && a_ok && (a_idx == IW'(i))) begin
               st_d[i]  = spec_wr ? LS_SPEC : LS_PLAIN;
               tag_d[i] = req_key;
            end
            if (need2 && a_ok && b_ok) begin
               if (a_idx == IW'(i)) begin
                  st_d[i]  = LS_SAVED;
                  tag_d[i] = req_key;
               end
               if (b_idx == IW'(i)) begin
                  st_d[i]  = LS_SPEC;
                  tag_d[i] = req_key;
               end
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < ENTRIES; i++) begin
            st_q[i]  <= LS_FREE;
            tag_q[i] <= '0;
         end
         abort_o          <= 1'b0;
         abort_conflict_o <= 1'b0;
         abort_overflow_o <= 1'b0;
         wb_valid_o       <= 1'b0;
         wb_mask_o        <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            st_q[i]  <= st_d[i];
            tag_q[i] <= tag_d[i];
         end
         abort_o          <= snp_conf | ovf;
         abort_conflict_o <= snp_conf;
         abort_overflow_o <= ovf;
         wb_valid_o       <= commit_go;
         wb_mask_o        <= commit_go ? spec_m : '0;
      end
   end

   // R5
   pair_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(spec_m) == $countones(saved_m));

   // R8
   commit_sweep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_go |=> (spec_m == '0) && (saved_m == '0));

   // R7
   abort_sweep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_go |=> (spec_m == '0) && (saved_m == '0));

   // R6
   snoop_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snoop_valid_i && (|(snp_eq & spec_m))) |=> (abort_o && abort_conflict_o));

   // R8
   wb_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid_o |-> ((wb_mask_o & ~plain_m) == '0));

   // R9
   ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_overflow_o |-> (abort_o && !abort_conflict_o));
endmodule

// File: tb/tsc_ctrl_tb.sv
`timescale 1ns/1ps
module tsc_ctrl_tb;
   localparam int N = 4;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rv = 0, rw = 0, rt = 0, sv = 0, cm = 0, ab = 0;
   logic [AW-1:0] ra = '0, sa = '0;
   logic hit, abt, aconf, aovf, wbv;
   logic [N-1:0] wbm;

   int n_chk = 0;
   int n_fail = 0;
   logic l_hit, l_abt, l_conf, l_ovf, l_wbv;
   logic [N-1:0] l_wbm;

   always #10 clk = ~clk;

   tsc_ctrl #(.ENTRIES(N), .LINE_BYTES(32), .ADDR_W(AW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(rv), .req_write_i(rw), .req_txn_i(rt), .req_addr_i(ra),
      .req_hit_o(hit),
      .snoop_valid_i(sv), .snoop_addr_i(sa),
      .txn_commit_i(cm), .txn_abort_i(ab),
      .abort_o(abt), .abort_conflict_o(aconf), .abort_overflow_o(aovf),
      .wb_valid_o(wbv), .wb_mask_o(wbm)
   );

   function automatic logic [AW-1:0] la(input int t, input int off);
      return AW'(t * 32 + off);
   endfunction

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // one cycle of stimulus; hit sampled before the edge, pulses after it
   task automatic op(input logic v, input logic w, input logic t, input logic [AW-1:0] a,
                     input logic s, input logic [AW-1:0] sadr, input logic c, input logic x);
      rv = v; rw = w; rt = t; ra = a; sv = s; sa = sadr; cm = c; ab = x;
      #1 l_hit = hit;
      @(posedge clk);
      @(negedge clk);
      rv = 0; rw = 0; rt = 0; sv = 0; cm = 0; ab = 0;
      l_abt = abt; l_conf = aconf; l_ovf = aovf; l_wbv = wbv; l_wbm = wbm;
   endtask

   task automatic rd(input int t, input int off);
      op(1, 0, 0, la(t, off), 0, '0, 0, 0);
   endtask
   task automatic twr(input int t);
      op(1, 1, 1, la(t, 0), 0, '0, 0, 0);
   endtask
   task automatic commit();
      op(0, 0, 0, '0, 0, '0, 1, 0);
   endtask
   task automatic snoop(input int t);
      op(0, 0, 0, '0, 1, la(t, 5), 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: first access misses, no pulses
      rd(0, 0);
      chk("R1 hit", l_hit, 0);
      chk("R1 abort", l_abt, 0);
      chk("R1 wb", l_wbv, 0);
      for (int i = 1; i < N; i++) begin
         rd(i, 0);
         chk("R3 fill miss", l_hit, 0);
      end
      // R2: offsets ignored
      for (int i = 0; i < N; i++) begin
         for (int off = 0; off < 32; off += 7) begin
            rd(i, off);
            chk("R2 hit with offset", l_hit, 1);
         end
      end
      // R4: full of Normal lines, lowest index evicted
      rd(4, 0);  chk("R4 miss", l_hit, 0);
      rd(0, 0);  chk("R4 tag0 evicted", l_hit, 0);
      rd(2, 3);  chk("R4 tag2 kept", l_hit, 1);
      // R5: txn write to Normal line (e1 -> saved, e0 -> spec)
      twr(1);    chk("R5 first txn write hits", l_hit, 1);
      twr(1);    chk("R5 second txn write hits", l_hit, 1);
      rd(0, 0);  chk("R5 tag0 evicted by spec copy", l_hit, 0);
      rd(2, 0);  chk("R4 tag2 evicted", l_hit, 0);
      // R6: snoop on Normal line is harmless
      snoop(3);
      chk("R6 no abort on normal snoop", l_abt, 0);
      // R8: commit publishes entry 0
      commit();
      chk("R8 wb valid", l_wbv, 1);
      chk("R8 wb mask", 32'(l_wbm), 32'h1);
      chk("R8 no abort", l_abt, 0);
      rd(1, 0);  chk("R8 committed line hits", l_hit, 1);
      rd(5, 0);  chk("R4 miss into free entry", l_hit, 0);
      rd(1, 0);  chk("R4 empty preferred over normal", l_hit, 1);
      rd(3, 0);  chk("R4 tag3 kept", l_hit, 1);
      // R6/R7: conflict abort restores saved copy
      twr(2);    chk("R5 txn write hit", l_hit, 1);
      rd(5, 0);  chk("R5 tag5 kept", l_hit, 1);
      snoop(2);
      chk("R6 abort", l_abt, 1);
      chk("R6 conflict cause", l_conf, 1);
      chk("R6 no overflow cause", l_ovf, 0);
      commit();
      chk("R7 no spec left", 32'(l_wbm), 0);
      rd(2, 0);  chk("R7 saved copy restored", l_hit, 1);
      rd(1, 0);  chk("R7 evicted line misses", l_hit, 0);
      // R9: overflow on pair allocation
      twr(6);    chk("R5 txn write miss", l_hit, 0);
      twr(7);    chk("R5 txn write miss", l_hit, 0);
      twr(8);
      chk("R9 abort", l_abt, 1);
      chk("R9 overflow cause", l_ovf, 1);
      chk("R9 no conflict cause", l_conf, 0);
      commit();
      chk("R9 request not performed", 32'(l_wbm), 0);
      rd(6, 0);  chk("R9 restored tag6", l_hit, 1);
      rd(7, 0);  chk("R9 restored tag7", l_hit, 1);
      rd(8, 0);  chk("R9 tag8 absent", l_hit, 0);
      // R9: overflow on single allocation
      twr(9);
      twr(10);
      rd(11, 0);
      chk("R9 single overflow abort", l_abt, 1);
      chk("R9 single overflow cause", l_ovf, 1);
      rd(9, 0);  chk("R7 tag9 normal", l_hit, 1);
      rd(10, 0); chk("R7 tag10 normal", l_hit, 1);
      // R10: conflict beats commit
      twr(9);
      op(0, 0, 0, '0, 1, la(9, 0), 1, 0);
      chk("R10 conflict wins", l_conf, 1);
      chk("R10 commit dropped", l_wbv, 0);
      // R10: request ignored during commit
      twr(9);
      op(1, 0, 0, la(12, 0), 0, '0, 1, 0);
      chk("R10 commit mask", 32'(l_wbm), 32'h1);
      rd(12, 0); chk("R10 request ignored", l_hit, 0);
      // R7: commanded abort raises nothing
      twr(10);
      op(0, 0, 0, '0, 0, '0, 0, 1);
      chk("R7 no abort pulse", l_abt, 0);
      rd(10, 0); chk("R7 tag10 restored", l_hit, 1);
      commit();
      chk("R7 mask empty", 32'(l_wbm), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule